// File: doc/BRIEF.md
# Ordered Multi-Domain Reset Sequencer

This block produces one active-low reset for each of several clock domains from a single active-low board reset. When the board reset goes low, every domain reset goes low straight away, with no clock needed. When the board reset is released, the domains come out of reset one after another in index order. Domain 0 leaves first, then domain 1, and so on. Each release is timed to the domain's own clock.

Each domain has a short shift-register synchronizer that the board reset clears asynchronously. Domain 0 shifts in a constant one. Every other domain shifts in the released state of the domain one index below it. This chaining makes the release order hold for any ratio between the clocks. A scan-test input forces every domain reset to its inactive level. The internal sequence keeps running underneath and is not affected.

Top module: `rstseq_top`

## Requirements
- R1: While `extRstN` is low and `testMode` is low, every bit of `rstOutN` is 0.
- R2: A falling edge on `extRstN` drives every bit of `rstOutN` to 0 at once, with no clock edge needed.
- R3: After `extRstN` rises, `rstOutN[0]` is still 0 after the first rising edge of `domClk[0]`. It becomes 1 on the second rising edge (`SYNC_DEPTH` = 2).
- R4: For a domain i > 0, `rstOutN[i]` is still 0 after the first rising edge of `domClk[i]` that follows the rise of `rstOutN[i-1]`. It becomes 1 on the second such edge.
- R5: The bits of `rstOutN` rise strictly in index order, 0 first. Bit i is never 1 while bit i-1 is 0 (with `testMode` low).
- R6: If `extRstN` falls while a sequence is partly done, all outputs return to 0 together. The next release restarts from domain 0 with the full latency of R3 and R4.
- R7: While `testMode` is 1, every bit of `rstOutN` is 1, whatever the state of `extRstN`. Once `testMode` returns to 0, the outputs again show the sequencer state (0 during reset, 1 once released).
- R8: Once a domain output has risen, it stays at 1 until `extRstN` falls again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| domClk | input | NUM_DOMAINS | One clock per domain; bit i times the release of domain i |
| extRstN | input | 1 | Shared asynchronous board reset, active low |
| testMode | input | 1 | Scan-test hold; forces every domain reset inactive |
| rstOutN | output | NUM_DOMAINS | Per-domain master reset, active low; bit 0 has highest priority |

## Verification
The hardest case to reach is a board reset that arrives while a sequence is half done. This is the moment when some domains are released and others are still counting edges. The stimulus waits for domain 0 to rise and then drops the board reset at a point where no clock edge falls nearby. It then releases the reset again and confirms the full two-edge latency of every domain. The three clocks run at unrelated periods and with fractional phase offsets, so no two edges ever coincide. This keeps every expected release edge unambiguous. A scoreboard queue catches any output that rises out of order.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/100ps
package rstseq_pkg;

  // Strobes from the control module to one domain of the datapath.
  typedef struct packed {
    logic chainIn;  // value shifted into the domain synchronizer
    logic holdOff;  // force the domain reset output inactive
  } domStrobe_t;

  localparam int MIN_DOMAINS = 2;
  localparam int MIN_SYNC_DEPTH = 2;

endpackage

// File: rtl/rstseq_sync_cell.sv
`timescale 1ns/100ps
module rstseq_sync_cell #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic clrN,
  input  logic chainIn,
  output logic released
);

  logic [SYNC_DEPTH-1:0] stage;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) stage <= '0;
    else       stage <= {stage[SYNC_DEPTH-2:0], chainIn};
  end

  assign released = stage[SYNC_DEPTH-1];

  // R3 R4: release only after the enable was seen SYNC_DEPTH edges earlier
  release_latency_chk: assert property (@(posedge clk) disable iff (!clrN)
    $rose(released) |-> $past(chainIn, SYNC_DEPTH));

  // R8
  sticky_release_chk: assert property (@(posedge clk) disable iff (!clrN)
    $past(released) |-> released);

endmodule

// File: rtl/rstseq_datapath.sv
`timescale 1ns/100ps
module rstseq_datapath
  import rstseq_pkg::*;
#(
  parameter int NUM_DOMAINS = 3,
  parameter int SYNC_DEPTH  = 2
) (
  input  logic [NUM_DOMAINS-1:0] domClk,
  input  logic                   extRstN,
  input  domStrobe_t [NUM_DOMAINS-1:0] strobes,
  output logic [NUM_DOMAINS-1:0] relSync,
  output logic [NUM_DOMAINS-1:0] rstOutN
);

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    rstseq_sync_cell #(.SYNC_DEPTH(SYNC_DEPTH)) u_cell (
      .clk      (domClk[d]),
      .clrN     (extRstN),
      .chainIn  (strobes[d].chainIn),
      .released (relSync[d])
    );

    assign rstOutN[d] = relSync[d] | strobes[d].holdOff;

    // R1
    reset_low_chk: assert property (@(posedge domClk[d]) disable iff (strobes[d].holdOff)
      !extRstN |-> !rstOutN[d]);

    if (d > 0) begin : g_order
      // R5
      release_order_chk: assert property (@(posedge domClk[d])
        disable iff (!extRstN || strobes[d].holdOff)
        rstOutN[d] |-> rstOutN[d-1]);
    end
  end

endmodule

// File: rtl/rstseq_ctrl.sv
`timescale 1ns/100ps
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int NUM_DOMAINS = 3
) (
  input  logic                   testMode,
  input  logic [NUM_DOMAINS-1:0] relSync,
  output domStrobe_t [NUM_DOMAINS-1:0] strobes
);

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_strb
    if (d == 0) begin : g_head
      assign strobes[d].chainIn = 1'b1;
    end else begin : g_link
      // chain on the synchronizer state, not the test-forced output
      assign strobes[d].chainIn = relSync[d-1];
    end
    assign strobes[d].holdOff = testMode;
  end

  // relSync[NUM_DOMAINS-1] drives no chain link; consumed here for completeness
  logic tailSeen;
  assign tailSeen = relSync[NUM_DOMAINS-1];
  always_comb begin
    if (tailSeen && !testMode) begin
      // R5: the last domain can only be released after the one above it
      tail_order_chk: assert (NUM_DOMAINS < 2 || relSync[NUM_DOMAINS-2]);
    end
  end

endmodule

// File: rtl/rstseq_top.sv
`timescale 1ns/100ps
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int NUM_DOMAINS = 3,
  parameter int SYNC_DEPTH  = 2
) (
  input  logic [NUM_DOMAINS-1:0] domClk,
  input  logic                   extRstN,
  input  logic                   testMode,
  output logic [NUM_DOMAINS-1:0] rstOutN
);

  if (NUM_DOMAINS < MIN_DOMAINS) begin : g_bad_count
    $error("rstseq_top: NUM_DOMAINS must be at least two");
  end
  if (SYNC_DEPTH < MIN_SYNC_DEPTH) begin : g_bad_depth
    $error("rstseq_top: SYNC_DEPTH must be at least two");
  end

  domStrobe_t [NUM_DOMAINS-1:0] strobes;
  logic [NUM_DOMAINS-1:0]       relSync;

  rstseq_ctrl #(.NUM_DOMAINS(NUM_DOMAINS)) u_ctrl (
    .testMode (testMode),
    .relSync  (relSync),
    .strobes  (strobes)
  );

  rstseq_datapath #(.NUM_DOMAINS(NUM_DOMAINS), .SYNC_DEPTH(SYNC_DEPTH)) u_dp (
    .domClk  (domClk),
    .extRstN (extRstN),
    .strobes (strobes),
    .relSync (relSync),
    .rstOutN (rstOutN)
  );

  always_comb begin
    if (testMode) begin
      // R7
      scan_hold_chk: assert (&rstOutN);
    end
  end

endmodule

// File: tb/rstseq_top_bench.sv
`timescale 1ns/100ps
module rstseq_top_bench;

  localparam int ND = 3;

  logic clkA, clkB, clkC;
  logic [ND-1:0] domClk;
  logic extRstN = 1'b1;
  logic testMode = 1'b0;
  logic [ND-1:0] rstOutN;

  assign domClk = {clkC, clkB, clkA};

  rstseq_top #(.NUM_DOMAINS(ND), .SYNC_DEPTH(2)) u_rstseq_top (
    .domClk   (domClk),
    .extRstN  (extRstN),
    .testMode (testMode),
    .rstOutN  (rstOutN)
  );

  // 125 MHz domain 0; unrelated periods with fractional phase on the others
  initial begin clkA = 1'b0; forever #4 clkA = ~clkA; end
  initial begin clkB = 1'b0; #0.3; forever #6.5 clkB = ~clkB; end
  initial begin clkC = 1'b0; #0.7; forever #2.5 clkC = ~clkC; end

  int vecCount = 0;
  int missCount = 0;
  int expQ[$];
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int d);
    case (d)
      0:       @(posedge clkA);
      1:       @(posedge clkB);
      default: @(posedge clkC);
    endcase
  endtask

  // Called just after the prerequisite of domain d became true.
  task automatic expectRise(input int d, input string req);
    waitClk(d); #0.1;
    check(rstOutN[d] == 1'b0, req, $sformatf("dom%0d after first edge", d), int'(rstOutN[d]), 0);
    waitClk(d); #0.1;
    check(rstOutN[d] == 1'b1, req, $sformatf("dom%0d after second edge", d), int'(rstOutN[d]), 1);
  endtask

  task automatic releaseAll(input string reqHead, input string reqChain);
    for (int d = 0; d < ND; d++) expQ.push_back(d);
    @(posedge clkA); #0.5;
    extRstN = 1'b1;
    expectRise(0, reqHead);
    for (int d = 1; d < ND; d++) expectRise(d, reqChain);
  endtask

  // Scoreboard monitor: each rising output must match the next expected domain
  for (genvar g = 0; g < ND; g++) begin : g_mon
    always @(posedge rstOutN[g]) begin
      if (!testMode) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5", $sformatf("unexpected rise of dom%0d", g), g, -1);
        end else begin
          int want;
          want = expQ.pop_front();
          check(want == g, "R5", "release order", g, want);
        end
        if (g > 0) check(rstOutN[g-1] == 1'b1, "R5", $sformatf("dom%0d above released", g-1),
                         int'(rstOutN[g-1]), 1);
      end
    end
  end

  initial begin
    #2 extRstN = 1'b0;
    repeat (5) @(posedge clkA);
    #0.5;
    check(rstOutN == '0, "R1", "all low in reset", int'(rstOutN), 0);

    testMode = 1'b1; #0.1;
    check(rstOutN == '1, "R7", "test hold in reset", int'(rstOutN), 7);
    #0.2 testMode = 1'b0; #0.1;
    check(rstOutN == '0, "R7", "back to reset after test", int'(rstOutN), 0);

    releaseAll("R3", "R4");
    check(expQ.size() == 0, "R5", "queue drained", expQ.size(), 0);

    repeat (20) @(posedge clkA);
    #0.5;
    check(rstOutN == '1, "R8", "outputs stay released", int'(rstOutN), 7);
    testMode = 1'b1; #0.1;
    check(rstOutN == '1, "R7", "test hold when released", int'(rstOutN), 7);
    testMode = 1'b0; #0.1;
    check(rstOutN == '1, "R7", "released after test", int'(rstOutN), 7);

    @(posedge clkA); #0.5;
    extRstN = 1'b0; #0.2;
    check(rstOutN == '0, "R2", "drop without clock", int'(rstOutN), 0);

    repeat (3) @(posedge clkA);
    for (int d = 0; d < ND; d++) expQ.push_back(d);
    @(posedge clkA); #0.5;
    extRstN = 1'b1;
    expectRise(0, "R3");
    #0.4 extRstN = 1'b0; #0.2;
    check(rstOutN == '0, "R6", "mid-sequence abort", int'(rstOutN), 0);
    expQ.delete();

    repeat (4) @(posedge clkA);
    #0.5;
    check(rstOutN == '0, "R1", "held low after abort", int'(rstOutN), 0);
    releaseAll("R6", "R6");
    check(expQ.size() == 0, "R6", "restart drained", expQ.size(), 0);
    repeat (10) @(posedge clkA);
    #0.5;
    check(rstOutN == '1, "R8", "stable after restart", int'(rstOutN), 7);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      vecCount++;
      missCount++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

endmodule